// File: doc/BRIEF.md
# I2C Target for a 24-Line I/O Expander

This block is the bus-facing core of a general-purpose I/O expander. It has 24 lines, grouped as three 8-bit ports. A host on a two-wire I2C bus addresses the block and writes a command byte. The command byte selects one of four register groups and a port within that group. The host then streams data bytes into that register, or reads bytes back from it. The system clock oversamples SCL and SDA, which arrive as plain inputs. The block pulls SDA low through an open-drain enable output.

The four groups are:
- the input view of the pins, with optional per-bit inversion;
- the output latch, which drives `out_val`;
- the polarity-inversion mask;
- the direction configuration, which drives `dir_cfg`.

The stored command survives across transfers. A read that begins straight after the address byte therefore returns the register chosen by the last write. Port k occupies bits [8k+7:8k] of every 24-bit bus.

Top module: `ioexp_i2c_target`

## Requirements
- R1: The block answers the 7-bit address made of 6'b010001 followed by `addr_sel`: 0x22 when low, 0x23 when high. Any other address gets no acknowledge, and the bus is ignored until the next START.
- R2: After a matching address byte, and after every byte the host writes, the block pulls SDA low for the whole ninth SCL pulse.
- R3: In a write transfer the first byte after the address is the command. Bits [3:2] select the group: 0 = input, 1 = output, 2 = polarity, 3 = configuration. Bits [1:0] select the port (0..2). Bits [7:4] are ignored.
- R4: A read transfer sends no command. It returns, MSB first, the register named by the stored command, and it never changes the group.
- R5: A read of the input group returns the pin level XOR the polarity register of that port.
- R6: `out_val` carries the output registers and `dir_cfg` carries the configuration registers. Reset values: output 0xFF, polarity 0x00, configuration 0xFF on every port.
- R7: After each written data byte, and after each read byte the host acknowledges, the port advances by one within the same group, wrapping from 2 to 0. Port index 3 does not advance.
- R8: Data written to the input group or to port index 3 is acknowledged but changes no register. Reads of port index 3 return 0x00.
- R9: A START or repeated START, even in the middle of a byte, restarts bit counting at the address byte. A STOP returns the block to idle and keeps the stored command.
- R10: When the host does not acknowledge a read byte, the block stops driving SDA until the next START.
- R11: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| addr_sel | input | 1 | Strap supplying the address LSB |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe | output | 1 | 1 pulls SDA low |
| pin_in | input | 24 | Line levels, port k in bits [8k+7:8k] |
| out_val | output | 24 | Output register contents |
| dir_cfg | output | 24 | Configuration registers, 1 = line is an input |

## Verification
The assertions assume a well-formed bus:
- SDA changes only while SCL is low, except at START and STOP.
- Every SCL level is held for many system clocks, longer than the synchronizer delay.
- The host never issues a START or STOP while the block is driving SDA.

The bench drives the bus with a bit-banged host whose SCL phases last ten system clocks. It changes SDA only a full phase after SCL falls, and it ends read bursts with a not-acknowledge before any STOP or repeated START. Strap and pin inputs change only while the bus is idle.

// File: rtl/ioexp_pkg.sv
package ioexp_pkg;
  localparam int BYTE_W    = 8;
  localparam int PORT_BITS = 2;
  localparam int GRP_BITS  = 2;

  typedef enum logic [GRP_BITS-1:0] {G_INPUT, G_OUTPUT, G_POLAR, G_CONFIG} grp_e;

  typedef struct packed {
    grp_e                 grp;
    logic [PORT_BITS-1:0] port;
  } ptr_t;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK, S_MWAIT} st_e;
  typedef enum logic [1:0] {K_ADDR, K_CMD, K_DATA} kind_e;

  // Next port inside the same group; out-of-range index stays put.
  function automatic ptr_t ptr_next(ptr_t p, int nports);
    ptr_t r;
    r = p;
    if (int'(p.port) == nports - 1)     r.port = '0;
    else if (int'(p.port) < nports - 1) r.port = p.port + PORT_BITS'(1);
    return r;
  endfunction
endpackage

// File: rtl/ioexp_bus_sync.sv
module ioexp_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      scl_d  <= scl_sr[STAGES-1];
      sda_d  <= sda_sr[STAGES-1];
    end
  end

  assign scl_q = scl_sr[STAGES-1];
  assign sda_q = sda_sr[STAGES-1];

  always_comb begin
    scl_rise = scl_q & ~scl_d;
    scl_fall = ~scl_q & scl_d;
    start_ev = scl_q & scl_d & sda_d & ~sda_q;
    stop_ev  = scl_q & scl_d & ~sda_d & sda_q;
  end
endmodule

// File: rtl/ioexp_regfile.sv
module ioexp_regfile
  import ioexp_pkg::*;
#(
  parameter int               NPORTS  = 3,
  parameter logic [BYTE_W-1:0] OUT_RST = 8'hFF,
  parameter logic [BYTE_W-1:0] POL_RST = 8'h00,
  parameter logic [BYTE_W-1:0] CFG_RST = 8'hFF
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NPORTS*BYTE_W-1:0] pin_in,
  input  logic                     wr_en,
  input  ptr_t                     wr_ptr,
  input  logic [BYTE_W-1:0]        wr_data,
  input  ptr_t                     rd_ptr,
  output logic [BYTE_W-1:0]        rd_data,
  output logic [NPORTS*BYTE_W-1:0] out_val,
  output logic [NPORTS*BYTE_W-1:0] dir_cfg
);
  localparam int W = NPORTS * BYTE_W;
  localparam logic [PORT_BITS-1:0] LAST_PORT = PORT_BITS'(NPORTS - 1);

  logic [BYTE_W-1:0] pin_r [NPORTS];
  logic [BYTE_W-1:0] out_r [NPORTS];
  logic [BYTE_W-1:0] pol_r [NPORTS];
  logic [BYTE_W-1:0] cfg_r [NPORTS];
  logic [W-1:0]      pol_flat;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    localparam logic [PORT_BITS-1:0] PIDX = PORT_BITS'(p);
    wire hit = wr_en && (wr_ptr.port == PIDX);

    always_ff @(posedge clk) begin
      if (rst) begin
        pin_r[p] <= '0;
        out_r[p] <= OUT_RST;
        pol_r[p] <= POL_RST;
        cfg_r[p] <= CFG_RST;
      end else begin
        pin_r[p] <= pin_in[p*BYTE_W +: BYTE_W];
        if (hit && wr_ptr.grp == G_OUTPUT) out_r[p] <= wr_data;
        if (hit && wr_ptr.grp == G_POLAR)  pol_r[p] <= wr_data;
        if (hit && wr_ptr.grp == G_CONFIG) cfg_r[p] <= wr_data;
      end
    end

    assign out_val [p*BYTE_W +: BYTE_W] = out_r[p];
    assign dir_cfg [p*BYTE_W +: BYTE_W] = cfg_r[p];
    assign pol_flat[p*BYTE_W +: BYTE_W] = pol_r[p];
  end

  always_comb begin
    rd_data = '0;
    if (rd_ptr.port <= LAST_PORT) begin
      case (rd_ptr.grp)
        G_INPUT:  rd_data = pin_r[rd_ptr.port] ^ pol_r[rd_ptr.port];
        G_OUTPUT: rd_data = out_r[rd_ptr.port];
        G_POLAR:  rd_data = pol_r[rd_ptr.port];
        default:  rd_data = cfg_r[rd_ptr.port];
      endcase
    end
  end

  // Ignored writes leave every writable register untouched.
  assert_ignored_write_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_ptr.grp == G_INPUT || wr_ptr.port > LAST_PORT)) |=>
      (out_val == $past(out_val) && dir_cfg == $past(dir_cfg) && pol_flat == $past(pol_flat)));

  // Only an accepted write may change the output or configuration ports.
  assert_regs_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (out_val == $past(out_val) && dir_cfg == $past(dir_cfg)));
endmodule

// File: rtl/ioexp_i2c_target.sv
module ioexp_i2c_target
  import ioexp_pkg::*;
#(
  parameter int         NPORTS      = 3,
  parameter int         SYNC_STAGES = 2,
  parameter logic [5:0] ADDR_HI     = 6'b010001
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     addr_sel,
  input  logic                     scl_i,
  input  logic                     sda_i,
  output logic                     sda_oe,
  input  logic [NPORTS*BYTE_W-1:0] pin_in,
  output logic [NPORTS*BYTE_W-1:0] out_val,
  output logic [NPORTS*BYTE_W-1:0] dir_cfg
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

  logic scl_q, sda_q, scl_rise, scl_fall, start_ev, stop_ev;

  ioexp_bus_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  st_e               state;
  kind_e             kind;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh, tx;
  logic              rw;
  ptr_t              ptr;
  logic [BYTE_W-1:0] rd_data;
  logic              byte_done, addr_hit, wr_en;

  assign byte_done = (state == S_RX) && scl_fall && (cnt == FULL);
  assign addr_hit  = (sh[7:1] == {ADDR_HI, addr_sel});
  assign wr_en     = byte_done && (kind == K_DATA);

  ioexp_regfile #(.NPORTS(NPORTS)) i_regs (
    .clk(clk), .rst(rst), .pin_in(pin_in),
    .wr_en(wr_en), .wr_ptr(ptr), .wr_data(sh),
    .rd_ptr(ptr), .rd_data(rd_data),
    .out_val(out_val), .dir_cfg(dir_cfg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      kind   <= K_ADDR;
      cnt    <= '0;
      sh     <= '0;
      tx     <= '0;
      rw     <= 1'b0;
      ptr    <= '0;
      sda_oe <= 1'b0;
    end else if (start_ev) begin
      state  <= S_RX;
      kind   <= K_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_ev) begin
      state  <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        S_RX: begin
          if (scl_rise && cnt < FULL) begin
            sh  <= {sh[BYTE_W-2:0], sda_q};
            cnt <= cnt + CNT_W'(1);
          end else if (byte_done) begin
            case (kind)
              K_ADDR: begin
                if (addr_hit) begin
                  rw     <= sh[0];
                  sda_oe <= 1'b1;
                  state  <= S_ACK;
                end else begin
                  state  <= S_IDLE;
                end
              end
              K_CMD: begin
                ptr    <= ptr_t'(sh[3:0]);
                sda_oe <= 1'b1;
                state  <= S_ACK;
              end
              default: begin
                ptr    <= ptr_next(ptr, NPORTS);
                sda_oe <= 1'b1;
                state  <= S_ACK;
              end
            endcase
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rw && kind == K_ADDR) begin
              tx     <= rd_data;
              sda_oe <= ~rd_data[BYTE_W-1];
              state  <= S_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= S_RX;
              kind   <= (kind == K_ADDR) ? K_CMD : K_DATA;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (cnt == LAST) begin
              sda_oe <= 1'b0;
              state  <= S_MACK;
            end else begin
              tx     <= {tx[BYTE_W-2:0], 1'b0};
              sda_oe <= ~tx[BYTE_W-2];
              cnt    <= cnt + CNT_W'(1);
            end
          end
        end
        S_MACK: begin
          if (scl_rise) begin
            if (sda_q) begin
              state <= S_IDLE;
            end else begin
              ptr   <= ptr_next(ptr, NPORTS);
              state <= S_MWAIT;
            end
          end
        end
        S_MWAIT: begin
          if (scl_fall) begin
            tx     <= rd_data;
            sda_oe <= ~rd_data[BYTE_W-1];
            cnt    <= '0;
            state  <= S_TX;
          end
        end
        default: ;
      endcase
    end
  end

  // A wrong address is never acknowledged and parks the block.
  assert_addr_reject_R1: assert property (@(posedge clk) disable iff (rst)
    (byte_done && kind == K_ADDR && !addr_hit) |=> (!sda_oe && state == S_IDLE));

  // Any START clears the bit counter and restarts at the address byte.
  assert_start_clears_R9: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> (cnt == '0 && kind == K_ADDR));

  // STOP never disturbs the stored command.
  assert_stop_keeps_ptr_R9: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> (ptr == $past(ptr)));

  // While idle (including after a host NACK) SDA is released.
  assert_idle_released_R10: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |-> !sda_oe);

  // SDA drive holds steady through an SCL high phase.
  assert_sda_steady_R11: assert property (@(posedge clk) disable iff (rst)
    (scl_q && $past(scl_q) && !$past(start_ev) && !$past(stop_ev)) |-> $stable(sda_oe));

  // A read transfer leaves the selected group unchanged.
  assert_read_keeps_grp_R4: assert property (@(posedge clk) disable iff (rst)
    (state == S_MACK && scl_rise) |=> (ptr.grp == $past(ptr.grp)));
endmodule

// File: tb/test_ioexp_i2c_target.sv
module test_ioexp_i2c_target;
  localparam int Q = 10;
  localparam int WDOG = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        addr_sel = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_oe;
  logic [23:0] pin_in = '0;
  logic [23:0] out_val, dir_cfg;
  wire         sda_line = sda_m & ~sda_oe;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int r11_viol = 0;
  logic scl_prev = 1'b1;
  logic oe_prev = 1'b0;

  always #4 clk = ~clk;

  ioexp_i2c_target i_ioexp_i2c_target (
    .clk(clk), .rst(rst), .addr_sel(addr_sel),
    .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .pin_in(pin_in), .out_val(out_val), .dir_cfg(dir_cfg)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic i2c_bit(input logic b);
    sda_m = b; wq(Q);
    scl_m = 1'b1; wq(2*Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic i2c_wbyte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) i2c_bit(b[i]);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    acked = (sda_line == 1'b0);
    wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic i2c_rbyte(input bit nack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      scl_m = 1'b1; wq(Q);
      d[i] = sda_line;
      wq(Q);
      scl_m = 1'b0; wq(Q);
    end
    sda_m = nack; wq(Q);
    scl_m = 1'b1; wq(2*Q);
    scl_m = 1'b0; wq(Q);
    sda_m = 1'b1;
  endtask

  // Write transfer: address, command, then n data bytes; every ack checked.
  task automatic wr_xfer(input logic [6:0] a, input logic [7:0] cmd,
                         input logic [7:0] d0, input logic [7:0] d1,
                         input logic [7:0] d2, input logic [7:0] d3, input int n);
    bit ak;
    logic [7:0] dd [4];
    dd[0] = d0; dd[1] = d1; dd[2] = d2; dd[3] = d3;
    i2c_start();
    i2c_wbyte({a, 1'b0}, ak); chk(ak, "R2 addr ack", ak, 1);
    i2c_wbyte(cmd, ak);       chk(ak, "R2 cmd ack", ak, 1);
    for (int i = 0; i < n; i++) begin
      i2c_wbyte(dd[i], ak);   chk(ak, "R2 data ack", ak, 1);
    end
    i2c_stop();
  endtask

  task automatic rd_expect(input logic [6:0] a, input logic [7:0] e0, input logic [7:0] e1,
                           input logic [7:0] e2, input int n, input string req);
    bit ak;
    logic [7:0] d;
    logic [7:0] ee [3];
    ee[0] = e0; ee[1] = e1; ee[2] = e2;
    i2c_start();
    i2c_wbyte({a, 1'b1}, ak); chk(ak, "R1 read addr ack", ak, 1);
    for (int i = 0; i < n; i++) begin
      i2c_rbyte(i == n - 1, d);
      chk(d == ee[i], req, d, ee[i]);
    end
    i2c_stop();
  endtask

  task automatic t_reset();
    chk(out_val == 24'hFFFFFF, "R6 out reset", out_val, 24'hFFFFFF);
    chk(dir_cfg == 24'hFFFFFF, "R6 cfg reset", dir_cfg, 24'hFFFFFF);
    chk(sda_oe == 1'b0, "R6 sda released", sda_oe, 0);
  endtask

  task automatic t_write_out();
    wr_xfer(7'h22, 8'h04, 8'h12, 8'h34, 8'h56, 8'h78, 4);
    chk(out_val == 24'h563478, "R7 wrap on write", out_val, 24'h563478);
  endtask

  task automatic t_read_ptr();
    rd_expect(7'h22, 8'h34, 8'h56, 8'h78, 3, "R4 R7 read from stored ptr");
  endtask

  task automatic t_input_pol();
    wr_xfer(7'h22, 8'h08, 8'hF0, 8'h00, 8'h00, 8'h00, 1);
    pin_in = 24'h00A53C;
    wr_xfer(7'h22, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 0);
    rd_expect(7'h22, 8'hCC, 8'hA5, 8'h00, 3, "R5 input xor polarity");
  endtask

  task automatic t_config();
    wr_xfer(7'h22, 8'h0C, 8'h0F, 8'hAA, 8'h55, 8'h00, 3);
    chk(dir_cfg == 24'h55AA0F, "R6 config out", dir_cfg, 24'h55AA0F);
    chk(out_val == 24'h563478, "R6 out kept", out_val, 24'h563478);
  endtask

  task automatic t_ignored();
    wr_xfer(7'h22, 8'h01, 8'hEE, 8'h00, 8'h00, 8'h00, 1);
    wr_xfer(7'h22, 8'h07, 8'h99, 8'h00, 8'h00, 8'h00, 1);
    chk(out_val == 24'h563478, "R8 out untouched", out_val, 24'h563478);
    chk(dir_cfg == 24'h55AA0F, "R8 cfg untouched", dir_cfg, 24'h55AA0F);
    wr_xfer(7'h22, 8'h0B, 8'h00, 8'h00, 8'h00, 8'h00, 0);
    rd_expect(7'h22, 8'h00, 8'h00, 8'h00, 2, "R8 undefined reads zero");
    wr_xfer(7'h22, 8'h08, 8'h00, 8'h00, 8'h00, 8'h00, 0);
    rd_expect(7'h22, 8'hF0, 8'h00, 8'h00, 3, "R8 polarity untouched");
    wr_xfer(7'h22, 8'hF4, 8'h11, 8'h00, 8'h00, 8'h00, 1);
    chk(out_val == 24'h563411, "R3 upper cmd bits ignored", out_val, 24'h563411);
  endtask

  task automatic t_addr();
    bit ak;
    addr_sel = 1'b1;
    wq(4);
    i2c_start();
    i2c_wbyte(8'h44, ak); chk(!ak, "R1 old address rejected", ak, 0);
    i2c_wbyte(8'h04, ak); chk(!ak, "R1 bus ignored", ak, 0);
    i2c_wbyte(8'h22, ak); chk(!ak, "R1 bus ignored", ak, 0);
    i2c_stop();
    chk(out_val == 24'h563411, "R1 no write", out_val, 24'h563411);
    wr_xfer(7'h23, 8'h06, 8'h5A, 8'h00, 8'h00, 8'h00, 1);
    chk(out_val == 24'h5A3411, "R1 strap address", out_val, 24'h5A3411);
  endtask

  task automatic t_stop_ptr();
    wr_xfer(7'h23, 8'h05, 8'h00, 8'h00, 8'h00, 8'h00, 0);
    rd_expect(7'h23, 8'h34, 8'h00, 8'h00, 1, "R9 ptr kept over STOP");
  endtask

  task automatic t_restart();
    bit ak;
    logic [7:0] d;
    i2c_start();
    i2c_bit(1'b1); i2c_bit(1'b0); i2c_bit(1'b1);
    i2c_start();
    i2c_wbyte(8'h46, ak); chk(ak, "R9 restart mid byte", ak, 1);
    i2c_wbyte(8'h06, ak); chk(ak, "R9 cmd after restart", ak, 1);
    i2c_start();
    i2c_wbyte(8'h47, ak); chk(ak, "R9 repeated start read", ak, 1);
    i2c_rbyte(1'b1, d);   chk(d == 8'h5A, "R9 read after rS", d, 8'h5A);
    i2c_stop();
  endtask

  task automatic t_nack();
    bit ak;
    logic [7:0] d;
    i2c_start();
    i2c_wbyte(8'h47, ak); chk(ak, "R10 addr ack", ak, 1);
    i2c_rbyte(1'b1, d);   chk(d == 8'h5A, "R10 first byte", d, 8'h5A);
    i2c_rbyte(1'b1, d);   chk(d == 8'hFF, "R10 released after nack", d, 8'hFF);
    chk(sda_oe == 1'b0, "R10 no drive", sda_oe, 0);
    i2c_stop();
  endtask

  always @(negedge clk) begin
    if (!rst && scl_m && scl_prev && sda_oe != oe_prev) r11_viol++;
    scl_prev <= scl_m;
    oe_prev  <= sda_oe;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WDOG) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    wq(5);
    rst = 1'b0;
    wq(5);
    t_reset();
    t_write_out();
    t_read_ptr();
    t_input_pol();
    t_config();
    t_ignored();
    t_addr();
    t_stop_ptr();
    t_restart();
    t_nack();
    chk(r11_viol == 0, "R11 drive only while SCL low", r11_viol, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule